// File: doc/BRIEF.md
# Pending Interrupt Queue Arbiter

This block gathers interrupt requests from numbered sources into a circular pending queue and decides, one cycle at a time, whether one of them goes to the processor core. Sources raise a request by presenting a vector number with a valid strobe, and the number is written into the queue at the write cursor. The core pulses a service strobe once per cycle of execution. A small wait counter models delivery latency: it is armed when an enabled request arrives, re-armed after a delivery attempt, and stretched by one when the global interrupt enable turns on.

When the counter runs out, the block scans every occupied queue slot and picks the lowest vector number. It removes that entry by moving the head entry into its slot and advancing the read cursor. The chosen vector is presented on a registered service output if its enable bit is set. If the bit is clear, the entry is dropped without being presented. Vector 0 is reserved for reset and is never queued. A raise of a vector that is already pending is ignored, so the queue never holds duplicates and cannot overflow.

Top module: `irq_pending_arbiter`

## Requirements
- R1: While reset is low and in the first cycle after it, `pend_any`, `pend_lines`, `svc_valid`, `svc_vec` and `wake_req` are all zero.
- R2: A raise with a nonzero vector that is not pending at the start of the cycle sets bit `raise_vec` of `pend_lines` after the next clock edge. A raise of vector 0 or of a pending vector has no effect.
- R3: `pend_any` is 1 exactly when at least one bit of `pend_lines` is 1.
- R4: An accepted raise whose `vec_enable` bit is 1, arriving while the wait counter is 0, loads the counter with 1.
- R5: A service strobe that finds the queue non-empty while the wait counter is 0 loads the counter with 2 and delivers nothing.
- R6: A service strobe that finds the queue non-empty while the counter is nonzero decrements it. When the counter reaches 0, the lowest pending vector is removed and its `pend_lines` bit clears. If enabled, it appears on `svc_vec` with `svc_valid` high for one cycle after that clock edge. `svc_vec` reads 0 whenever `svc_valid` is low.
- R7: If the vector chosen for delivery has its `vec_enable` bit clear in that cycle, it is removed and its `pend_lines` bit clears, but `svc_valid` stays low.
- R8: When `gie` is 1 and its registered copy from the previous cycle is 0, the counter increments by one, saturating at 7. The copy resets to 0.
- R9: An accepted, enabled raise while `core_running` is 0 gives a one-cycle `wake_req` pulse after the next clock edge.
- R10: Within one cycle, the raise rule is applied to the counter first, then the `gie` edge, then the service rule. The service rule sees the queue as it stood at the start of the cycle, so a vector raised in that cycle is not yet eligible.
- R11: All 63 nonzero vectors can be pending together. The cursors wrap modulo the queue depth of 64 with no loss or duplication of entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| raise_valid | input | 1 | A source is raising the vector on `raise_vec` |
| raise_vec | input | 6 | Number of the vector being raised |
| vec_enable | input | 64 | Per-vector enable bits |
| gie | input | 1 | Global interrupt enable |
| core_running | input | 1 | Core is running (low: asleep) |
| svc_strobe | input | 1 | Per-cycle service attempt from the core |
| pend_any | output | 1 | Queue holds at least one entry |
| pend_lines | output | 64 | Per-vector pending lines |
| svc_valid | output | 1 | A vector is being delivered this cycle |
| svc_vec | output | 6 | Delivered vector number, 0 when idle |
| wake_req | output | 1 | Wake request toward a sleeping core |

## Verification
The hardest state to reach is a long-lived queue whose read and write cursors have wrapped several times. It must also hold entries in an order scrambled by earlier head-into-slot swaps, so that the lowest vector sits away from the head. Random raises at a rate above the delivery rate keep dozens of vectors queued while service strobes keep removing entries from the middle. A directed fill of all 63 vectors followed by a full drain checks the case where the queue holds its maximum. Directed sequences also place `gie` edges, raises and strobes in the same cycle to pin down the order in which the counter rules are applied.

// File: rtl/irq_pq_pkg.sv
// Package: shared widths and helpers for the pending interrupt arbiter.
// Assumes vector and queue counts are powers of two.
package irq_pq_pkg;

    // Default number of vector numbers (vector 0 is reserved).
    localparam int DEF_NUM_VEC = 64;
    // Default queue depth; must be a power of two and >= DEF_NUM_VEC.
    localparam int DEF_DEPTH   = 64;
    // Default width of the latency counter.
    localparam int DEF_WAIT_W  = 3;

    // Action taken by the latency counter in one cycle.
    typedef enum logic [1:0] {
        WT_HOLD = 2'd0,
        WT_ARM  = 2'd1,
        WT_STEP = 2'd2
    } wait_act_e;

endpackage

// File: rtl/irq_wait_timer.sv
// Module: latency countdown for interrupt delivery.
// Applies, in order, the raise arm rule, the global-enable edge bump
// and the service rule, and flags the cycle in which delivery fires.
// Assumes WAIT_W >= 2 so that the re-arm value 2 fits.
module irq_wait_timer
    import irq_pq_pkg::*;
#(
    parameter int WAIT_W = DEF_WAIT_W
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raise_arm,
    input  logic gie,
    input  logic svc_req,
    output logic fire
);
    localparam logic [WAIT_W-1:0] CNT_MAX = '1;
    localparam logic [WAIT_W-1:0] CNT_ONE = WAIT_W'(1);
    localparam logic [WAIT_W-1:0] CNT_TWO = WAIT_W'(2);

    logic [WAIT_W-1:0] cnt_q, cnt_d, after_raise, after_edge;
    logic              gie_shadow_q, gie_rise;
    wait_act_e         act;

    assign gie_rise = gie && !gie_shadow_q;

    // Purpose: combine the three counter rules in their fixed order.
    always_comb begin
        after_raise = (raise_arm && cnt_q == '0) ? CNT_ONE : cnt_q;
        after_edge  = (gie_rise && after_raise != CNT_MAX) ? after_raise + CNT_ONE : after_raise;
        if (!svc_req)                act = WT_HOLD;
        else if (after_edge == '0)   act = WT_ARM;
        else                         act = WT_STEP;
        fire  = 1'b0;
        cnt_d = after_edge;
        case (act)
            WT_ARM:  cnt_d = CNT_TWO;
            WT_STEP: begin
                cnt_d = after_edge - CNT_ONE;
                fire  = (after_edge == CNT_ONE);
            end
            default: cnt_d = after_edge;
        endcase
    end

    // Purpose: hold the counter and the shadow of the global enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q        <= '0;
            gie_shadow_q <= 1'b0;
        end else begin
            cnt_q        <= cnt_d;
            gie_shadow_q <= gie;
        end
    end
endmodule

// File: rtl/irq_min_select.sv
// Module: finds the occupied queue slot with the lowest vector number.
// A balanced compare tree, one level per address bit; vector numbers
// in the queue are unique, so ties do not arise.
// Assumes DEPTH is a power of two.
module irq_min_select #(
    parameter int DEPTH = 64,
    parameter int VW    = 6
) (
    input  logic [DEPTH*VW-1:0]      slots,
    input  logic [DEPTH-1:0]         occ,
    output logic                     found,
    output logic [$clog2(DEPTH)-1:0] sel_idx,
    output logic [VW-1:0]            sel_vec
);
    localparam int PW = $clog2(DEPTH);

    for (genvar lv = 0; lv <= PW; lv++) begin : g_lvl
        localparam int N = DEPTH >> lv;
        logic [N-1:0]    f;
        logic [N*VW-1:0] v;
        logic [N*PW-1:0] x;
        if (lv == 0) begin : g_leaf
            for (genvar j = 0; j < N; j++) begin : g_n
                assign f[j]           = occ[j];
                assign v[j*VW +: VW]  = slots[j*VW +: VW];
                assign x[j*PW +: PW]  = PW'(j);
            end
        end else begin : g_node
            for (genvar j = 0; j < N; j++) begin : g_n
                logic          lf, rf, take_left;
                logic [VW-1:0] lvv, rvv;
                assign lf  = g_lvl[lv-1].f[2*j];
                assign rf  = g_lvl[lv-1].f[2*j+1];
                assign lvv = g_lvl[lv-1].v[(2*j)*VW +: VW];
                assign rvv = g_lvl[lv-1].v[(2*j+1)*VW +: VW];
                // Purpose: keep the occupied child with the smaller number.
                assign take_left = lf && (!rf || lvv <= rvv);
                assign f[j]          = lf || rf;
                assign v[j*VW +: VW] = take_left ? lvv : rvv;
                assign x[j*PW +: PW] = take_left ? g_lvl[lv-1].x[(2*j)*PW +: PW]
                                                 : g_lvl[lv-1].x[(2*j+1)*PW +: PW];
            end
        end
    end

    assign found   = g_lvl[PW].f[0];
    assign sel_vec = g_lvl[PW].v[VW-1:0];
    assign sel_idx = g_lvl[PW].x[PW-1:0];
endmodule

// File: rtl/irq_pending_store.sv
// Module: circular pending queue with per-vector pending marks.
// Push writes at the write cursor; pop removes an arbitrary slot by
// copying the head entry into it and advancing the read cursor.
// Assumes push and pop never target the same slot (the queue is never
// full because duplicates are refused upstream).
module irq_pending_store #(
    parameter int DEPTH   = 64,
    parameter int NUM_VEC = 64,
    parameter int VW      = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     push,
    input  logic [VW-1:0]            push_vec,
    input  logic                     pop,
    input  logic [$clog2(DEPTH)-1:0] pop_idx,
    input  logic [VW-1:0]            pop_vec,
    output logic [DEPTH*VW-1:0]      slots,
    output logic [DEPTH-1:0]         occ,
    output logic                     empty,
    output logic [NUM_VEC-1:0]       marks
);
    localparam int PW = $clog2(DEPTH);

    logic [PW-1:0] rd_q, wr_q, count;
    logic [VW-1:0] head_vec;

    assign count    = wr_q - rd_q;
    assign empty    = (count == '0);
    assign head_vec = slots[rd_q*VW +: VW];

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        logic [VW-1:0] q;
        logic [PW-1:0] off;
        assign off                = PW'(i) - rd_q;
        assign occ[i]             = (off < count);
        assign slots[i*VW +: VW]  = q;
        // Purpose: load a new entry or take the head entry on removal.
        always_ff @(posedge clk) begin
            if (push && wr_q == PW'(i))
                q <= push_vec;
            else if (pop && pop_idx == PW'(i))
                q <= head_vec;
        end
    end

    // Purpose: advance the cursors, wrapping modulo the depth.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= '0;
            wr_q <= '0;
        end else begin
            if (push) wr_q <= wr_q + PW'(1);
            if (pop)  rd_q <= rd_q + PW'(1);
        end
    end

    // Purpose: set the mark of a queued vector, clear it on removal.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            marks <= '0;
        end else begin
            if (pop)  marks[pop_vec]  <= 1'b0;
            if (push) marks[push_vec] <= 1'b1;
        end
    end
endmodule

// File: rtl/irq_pending_arbiter.sv
// Module: top of the pending interrupt queue arbiter.
// Accepts one raise per cycle, refuses vector 0 and vectors already
// pending, and on each service strobe lets the latency counter decide
// whether the lowest pending vector is delivered or dropped.
// Assumes NUM_VEC is a power of two and DEPTH >= NUM_VEC.
module irq_pending_arbiter
    import irq_pq_pkg::*;
#(
    parameter int NUM_VEC = DEF_NUM_VEC,
    parameter int DEPTH   = DEF_DEPTH,
    parameter int WAIT_W  = DEF_WAIT_W,
    localparam int VW     = $clog2(NUM_VEC),
    localparam int PW     = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               raise_valid,
    input  logic [VW-1:0]      raise_vec,
    input  logic [NUM_VEC-1:0] vec_enable,
    input  logic               gie,
    input  logic               core_running,
    input  logic               svc_strobe,
    output logic               pend_any,
    output logic [NUM_VEC-1:0] pend_lines,
    output logic               svc_valid,
    output logic [VW-1:0]      svc_vec,
    output logic               wake_req
);
    logic                raise_ok, raise_arm, svc_req, fire, found, empty;
    logic [DEPTH*VW-1:0] slots;
    logic [DEPTH-1:0]    occ;
    logic [PW-1:0]       sel_idx;
    logic [VW-1:0]       sel_vec;
    logic                deliver;

    // Purpose: qualify a raise and the service attempt.
    assign raise_ok  = raise_valid && (raise_vec != '0) && !pend_lines[raise_vec];
    assign raise_arm = raise_ok && vec_enable[raise_vec];
    assign svc_req   = svc_strobe && !empty;
    assign deliver   = fire && found && vec_enable[sel_vec];
    assign pend_any  = !empty;

    irq_wait_timer #(.WAIT_W(WAIT_W)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .raise_arm (raise_arm),
        .gie       (gie),
        .svc_req   (svc_req),
        .fire      (fire)
    );

    irq_pending_store #(.DEPTH(DEPTH), .NUM_VEC(NUM_VEC), .VW(VW)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (raise_ok),
        .push_vec (raise_vec),
        .pop      (fire && found),
        .pop_idx  (sel_idx),
        .pop_vec  (sel_vec),
        .slots    (slots),
        .occ      (occ),
        .empty    (empty),
        .marks    (pend_lines)
    );

    irq_min_select #(.DEPTH(DEPTH), .VW(VW)) u_select (
        .slots   (slots),
        .occ     (occ),
        .found   (found),
        .sel_idx (sel_idx),
        .sel_vec (sel_vec)
    );

    // Purpose: register the delivery and the wake request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            svc_valid <= 1'b0;
            svc_vec   <= '0;
            wake_req  <= 1'b0;
        end else begin
            svc_valid <= deliver;
            svc_vec   <= deliver ? sel_vec : '0;
            wake_req  <= raise_arm && !core_running;
        end
    end
endmodule

// File: rtl/irq_pending_arbiter_chk.sv
// Module: assertion checker for irq_pending_arbiter, bound below.
module irq_pending_arbiter_chk #(
    parameter int NUM_VEC = 64,
    parameter int VW      = 6
) (
    input logic               clk,
    input logic               rst_n,
    input logic               raise_valid,
    input logic               core_running,
    input logic               svc_strobe,
    input logic [NUM_VEC-1:0] vec_enable,
    input logic               pend_any,
    input logic [NUM_VEC-1:0] pend_lines,
    input logic               svc_valid,
    input logic [VW-1:0]      svc_vec,
    input logic               wake_req
);
    logic [NUM_VEC-1:0] prev_lines, prev_en, below;

    // Purpose: remember last cycle's pending lines and enables.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_lines <= '0;
            prev_en    <= '0;
        end else begin
            prev_lines <= pend_lines;
            prev_en    <= vec_enable;
        end
    end

    assign below = (NUM_VEC'(1) << svc_vec) - NUM_VEC'(1);

    assert_vec0_never_pending_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !pend_lines[0]);
    assert_any_matches_lines_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pend_any == (pend_lines != '0));
    assert_lowest_delivered_R6: assert property (@(posedge clk) disable iff (!rst_n)
        svc_valid |-> (prev_lines[svc_vec] && ((prev_lines & below) == '0)));
    assert_delivered_cleared_R6: assert property (@(posedge clk) disable iff (!rst_n)
        svc_valid |-> !pend_lines[svc_vec]);
    assert_needs_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        svc_valid |-> $past(svc_strobe));
    assert_delivered_enabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
        svc_valid |-> prev_en[svc_vec]);
    assert_wake_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wake_req |-> ($past(raise_valid) && !$past(core_running)));
endmodule

bind irq_pending_arbiter irq_pending_arbiter_chk #(.NUM_VEC(NUM_VEC), .VW(VW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .raise_valid  (raise_valid),
    .core_running (core_running),
    .svc_strobe   (svc_strobe),
    .vec_enable   (vec_enable),
    .pend_any     (pend_any),
    .pend_lines   (pend_lines),
    .svc_valid    (svc_valid),
    .svc_vec      (svc_vec),
    .wake_req     (wake_req)
);

// File: tb/test_irq_pending_arbiter.sv
// Bench: directed corner cases plus seeded random traffic, checked
// against a set-based reference model held in bench functions.
module test_irq_pending_arbiter;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        raise_valid;
    logic [5:0]  raise_vec;
    logic [63:0] vec_enable;
    logic        gie, core_running, svc_strobe;
    logic        pend_any, svc_valid, wake_req;
    logic [63:0] pend_lines;
    logic [5:0]  svc_vec;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    // Reference model state.
    bit [63:0] m_pend;
    int        m_wait;
    bit        m_shadow;
    bit        e_valid, e_wake;
    int        e_vec;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_pending_arbiter i_irq_pending_arbiter (
        .clk(clk), .rst_n(rst_n), .raise_valid(raise_valid), .raise_vec(raise_vec),
        .vec_enable(vec_enable), .gie(gie), .core_running(core_running),
        .svc_strobe(svc_strobe), .pend_any(pend_any), .pend_lines(pend_lines),
        .svc_valid(svc_valid), .svc_vec(svc_vec), .wake_req(wake_req)
    );

    function automatic int lowest(bit [63:0] s);
        for (int i = 0; i < 64; i++) if (s[i]) return i;
        return 0;
    endfunction

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Advance the model with the current inputs (order per R10).
    task automatic model_step();
        bit ok;
        int w;
        int sel;
        ok = raise_valid && raise_vec != 0 && !m_pend[raise_vec];
        w  = m_wait;
        if (ok && vec_enable[raise_vec] && w == 0) w = 1;
        if (gie && !m_shadow && w < 7) w++;
        e_valid = 0; e_vec = 0;
        if (svc_strobe && m_pend != 0) begin
            if (w == 0) w = 2;
            else begin
                w--;
                if (w == 0) begin
                    sel = lowest(m_pend);
                    m_pend[sel] = 1'b0;
                    if (vec_enable[sel]) begin e_valid = 1; e_vec = sel; end
                end
            end
        end
        if (ok) m_pend[raise_vec] = 1'b1;
        e_wake   = ok && vec_enable[raise_vec] && !core_running;
        m_shadow = gie;
        m_wait   = w;
    endtask

    // One clock with the inputs already set; compares at the next negedge.
    task automatic cycle();
        model_step();
        @(posedge clk);
        @(negedge clk);
        check("R2 pend_lines", pend_lines, m_pend);
        check("R3 pend_any", 64'(pend_any), 64'(m_pend != 0));
        check("R6 svc_valid", 64'(svc_valid), 64'(e_valid));
        check("R6 svc_vec", 64'(svc_vec), 64'(e_vec));
        check("R9 wake_req", 64'(wake_req), 64'(e_wake));
    endtask

    task automatic idle_in();
        raise_valid = 0; raise_vec = 0; svc_strobe = 0;
    endtask

    task automatic raise1(int v, bit svc);
        raise_valid = 1; raise_vec = 6'(v); svc_strobe = svc;
        cycle();
        idle_in();
    endtask

    task automatic svc1();
        svc_strobe = 1;
        cycle();
        svc_strobe = 0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    endtask

    // Watchdog: an expired run counts as a failed check.
    initial begin
        #(CLK_PERIOD * 150000);
        n_checks++; n_fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 0; idle_in(); vec_enable = '1; gie = 0; core_running = 1;
        m_pend = 0; m_wait = 0; m_shadow = 0;
        repeat (3) @(negedge clk);
        check("R1 reset pend_lines", pend_lines, 0);
        check("R1 reset pend_any", 64'(pend_any), 0);
        check("R1 reset svc", {svc_valid, svc_vec, wake_req}, 0);
        rst_n = 1;
        cycle();
        check("R1 after reset", {pend_any, svc_valid, wake_req}, 0);

        // R4: enabled raise arms counter to 1; next strobe delivers.
        raise1(5, 0);
        svc1();
        check("R4 deliver after one strobe", {svc_valid, svc_vec}, {1'b1, 6'd5});

        // R5, R7: disabled vector, counter at 0: strobe re-arms to 2, then drop.
        vec_enable[9] = 0;
        raise1(9, 0);
        svc1();
        check("R5 no delivery on arm", {svc_valid, pend_lines[9]}, 2'b01);
        svc1();
        svc1();
        check("R7 dropped not delivered", {svc_valid, pend_lines[9]}, 2'b00);
        vec_enable[9] = 1;

        // R2: vector 0 and duplicates are refused.
        raise1(0, 0);
        check("R2 vec0 ignored", {pend_any, pend_lines}, 0);
        raise1(7, 0);
        raise1(7, 0);
        check("R2 duplicate ignored", pend_lines, 64'h80);
        svc1();
        check("R2 single delivery of 7", {svc_valid, svc_vec}, {1'b1, 6'd7});
        svc1();
        check("R2 no second copy", {svc_valid, pend_any}, 2'b00);

        // R8: gie edge stretches the counter by one.
        gie = 1;
        raise1(4, 0);
        svc1();
        check("R8 stretched, no delivery yet", {svc_valid, pend_lines[4]}, 2'b01);
        svc1();
        check("R8 delivered after stretch", {svc_valid, svc_vec}, {1'b1, 6'd4});

        // R6: lowest number wins regardless of arrival order.
        raise1(40, 0); raise1(12, 0); raise1(33, 0);
        svc1();
        check("R6 lowest first", {svc_valid, svc_vec}, {1'b1, 6'd12});

        // R10: raise with strobe on empty queue is not yet eligible.
        while (m_pend != 0) svc1();
        raise1(20, 1);
        check("R10 raise not eligible same cycle", {svc_valid, pend_lines[20]}, 2'b01);
        svc1();
        check("R10 delivered next strobe", {svc_valid, svc_vec}, {1'b1, 6'd20});

        // R9: wake while the core sleeps.
        core_running = 0;
        raise1(3, 0);
        check("R9 wake pulse", 64'(wake_req), 1);
        cycle();
        check("R9 wake one cycle", 64'(wake_req), 0);
        core_running = 1;
        while (m_pend != 0) svc1();

        // R11: fill all 63 vectors, then drain in ascending order.
        for (int v = 63; v >= 1; v--) raise1(v, 0);
        check("R11 all pending", pend_lines, 64'hFFFF_FFFF_FFFF_FFFE);
        for (int k = 0; k < 400 && m_pend != 0; k++) svc1();
        check("R11 drained", {pend_any, pend_lines}, 0);

        // Random traffic: cursors wrap many times (R11).
        for (int c = 0; c < 6000; c++) begin
            raise_valid  = ($urandom % 4) != 0;
            raise_vec    = 6'($urandom);
            svc_strobe   = ($urandom % 3) != 0;
            core_running = ($urandom % 4) != 0;
            if ($urandom % 8 == 0) gie = ~gie;
            if ($urandom % 16 == 0) vec_enable = {$urandom, $urandom} | {$urandom, $urandom};
            cycle();
        end
        idle_in();
        finish_run();
    end
endmodule